// File: doc/BRIEF.md
# IO Coherency Aperture Decoder

This block sorts addresses arriving from an IO port into two classes. A programmable window of the address space, the coherent aperture, is served by the coherent path. Every address outside it goes to the non-coherent path. Software sets up the window through a small register port. The window size is held as a log2 code, where the size in bytes is 2^(code+12), so code 0 gives 4 KB, 0x11 gives 512 MB and 0x12 gives 1 GB. The window start is held in 4 KB units and must be a multiple of the window size.

Each valid request carries one address. One clock later the block gives a registered routing decision. The decision has three parts: a valid strobe, a coherent flag, and a partial-coherency flag that qualifies a coherent hit. If the programmed start is not aligned to the window size, a configuration-error flag is raised. While it is raised, no request hits. The flag stays raised until a later write to the size or start register leaves the pair aligned.

Top module: `ioc_aperture_dec`

## Requirements
- R1: After reset, all four registers read as zero, cfg_err is 0, and route_vld, route_coh and route_part are 0.
- R2: A read (reg_rd=1) returns the stored value on reg_rdata one cycle later. The register offsets are: 0 = size code in bits [4:0]; 1 = start address divided by 4096, in bits [ADDR_W-13:0]; 2 = partial-coherency mode in bit 0; 3 = enable in bit 0. All other bits read as zero, whatever was written to them.
- R3: When enabled and with no configuration error, an address hits exactly when it lies in [base*4096, base*4096 + 2^(code+12)). A hit sets route_coh=1, and a miss leaves it 0.
- R4: While enable is 0, no request sets route_coh, whatever the address.
- R5: The window bounds are exact. With code 0x11 the window spans 512 MB: the first and last byte hit, and the bytes just below and just above it miss. With code 0 the window is a single 4 KB page.
- R6: If base*4096 is not a multiple of the window size, cfg_err becomes 1 in the cycle after the write and no request hits. cfg_err changes only on a write to the size or base register, and a write that leaves the pair aligned clears it.
- R7: A size code with code+12 >= ADDR_W makes the window cover the whole address space. Any address then hits, provided the base is 0; any other base raises cfg_err.
- R8: route_part is 1 only on a coherent hit while partial mode is 1.
- R9: route_vld is 1 exactly in the cycle after a cycle with req_vld=1. route_coh and route_part are 0 whenever route_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after reg_rd |
| req_vld | input | 1 | Request valid |
| req_addr | input | ADDR_W | Request address |
| route_vld | output | 1 | Routing decision valid |
| route_coh | output | 1 | 1 = coherent path, 0 = non-coherent path |
| route_part | output | 1 | Coherent hit under partial-coherency mode |
| cfg_err | output | 1 | Start address not aligned to window size |

## Verification
Requests are sent at the first byte, the last byte and the bytes just outside a 512 MB window and a 4 KB window. These probes show whether the comparison stops at the right bit, not one bit too high or too low. The same in-window address is sent with enable off, then partial mode off, then partial mode on, which separates the enable gate from the partial qualifier. A misaligned start is probed at addresses that would fall inside the window if the alignment were ignored. Oversized size codes are probed at the extremes of the address space, which separates clamping from wraparound of the shift.

// File: rtl/ioc_ap_pkg.sv
package ioc_ap_pkg;
  localparam int CODE_W = 5;
  localparam int PAGE_SH = 12;

  typedef enum logic [1:0] {
    OFS_SIZE = 2'd0,
    OFS_BASE = 2'd1,
    OFS_MODE = 2'd2,
    OFS_EN   = 2'd3
  } ap_ofs_e;
endpackage

// File: rtl/ioc_ap_regs.sv
module ioc_ap_regs
  import ioc_ap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CODE_W-1:0] size_code,
  output logic [ADDR_W-PAGE_SH-1:0] base_pg,
  output logic              partial,
  output logic              en,
  output logic              cfg_err
);
  localparam int BASE_W = ADDR_W - PAGE_SH;

  // base page bits below the code index must be clear for alignment
  function automatic logic misaligned(input logic [CODE_W-1:0] c,
                                      input logic [BASE_W-1:0] b);
    logic r;
    r = 1'b0;
    for (int i = 0; i < BASE_W; i++)
      if (i < int'(c) && b[i]) r = 1'b1;
    return r;
  endfunction

  logic cfg_wr;
  assign cfg_wr = wr && (ofs == OFS_SIZE || ofs == OFS_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      size_code <= '0;
      base_pg   <= '0;
      partial   <= 1'b0;
      en        <= 1'b0;
      cfg_err   <= 1'b0;
      rdata     <= '0;
    end else begin
      if (wr) begin
        case (ap_ofs_e'(ofs))
          OFS_SIZE: begin
            size_code <= wdata[CODE_W-1:0];
            cfg_err   <= misaligned(wdata[CODE_W-1:0], base_pg);
          end
          OFS_BASE: begin
            base_pg <= wdata[BASE_W-1:0];
            cfg_err <= misaligned(size_code, wdata[BASE_W-1:0]);
          end
          OFS_MODE: partial <= wdata[0];
          OFS_EN:   en      <= wdata[0];
          default:  ;
        endcase
      end
      if (rd) begin
        rdata <= '0;
        case (ap_ofs_e'(ofs))
          OFS_SIZE: rdata[CODE_W-1:0] <= size_code;
          OFS_BASE: rdata[BASE_W-1:0] <= base_pg;
          OFS_MODE: rdata[0]          <= partial;
          OFS_EN:   rdata[0]          <= en;
          default:  ;
        endcase
      end
    end
  end

  // R6: the error flag moves only on a size or base write
  a_r6_err_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(cfg_err));

  // R2: single-bit registers read back with upper bits clear
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && (ofs == OFS_MODE || ofs == OFS_EN)) |=> (rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/ioc_ap_match.sv
module ioc_ap_match
  import ioc_ap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CODE_W-1:0]         size_code,
  input  logic [ADDR_W-PAGE_SH-1:0] base_pg,
  input  logic                      en,
  input  logic                      cfg_err,
  output logic                      hit
);
  localparam int SH_W = $clog2(ADDR_W + PAGE_SH + (1 << CODE_W)) + 1;

  logic [SH_W-1:0]   win_sh;
  logic [ADDR_W-1:0] keep;
  logic [ADDR_W-1:0] base_addr;

  assign win_sh    = SH_W'(size_code) + SH_W'(PAGE_SH);
  assign base_addr = {base_pg, {PAGE_SH{1'b0}}};

  // bits at or above the window size take part in the compare; an
  // oversized code leaves none, so the window spans the whole space
  for (genvar i = 0; i < ADDR_W; i++) begin : g_keep
    assign keep[i] = (SH_W'(i) >= win_sh);
  end

  assign hit = en && !cfg_err && (((addr ^ base_addr) & keep) == '0);
endmodule

// File: rtl/ioc_aperture_dec.sv
module ioc_aperture_dec
  import ioc_ap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              route_vld,
  output logic              route_coh,
  output logic              route_part,
  output logic              cfg_err
);
  logic [CODE_W-1:0]         size_code;
  logic [ADDR_W-PAGE_SH-1:0] base_pg;
  logic                      partial;
  logic                      en;
  logic                      hit;

  ioc_ap_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .ofs(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .size_code(size_code),
    .base_pg(base_pg), .partial(partial), .en(en), .cfg_err(cfg_err)
  );

  ioc_ap_match #(.ADDR_W(ADDR_W)) u_match (
    .addr(req_addr), .size_code(size_code), .base_pg(base_pg),
    .en(en), .cfg_err(cfg_err), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      route_vld  <= 1'b0;
      route_coh  <= 1'b0;
      route_part <= 1'b0;
    end else begin
      route_vld  <= req_vld;
      route_coh  <= req_vld && hit;
      route_part <= req_vld && hit && partial;
    end
  end

  a_r9_vld_follows: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> route_vld);
  a_r9_vld_idle: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !route_vld);
  a_r9_coh_needs_vld: assert property (@(posedge clk) disable iff (rst)
    route_coh |-> route_vld);
  a_r8_part_needs_coh: assert property (@(posedge clk) disable iff (rst)
    route_part |-> route_coh);
  a_r4_disabled_miss: assert property (@(posedge clk) disable iff (rst)
    !en |=> !route_coh);
  a_r6_err_miss: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !route_coh);
endmodule

// File: tb/tb_ioc_aperture_dec.sv
`timescale 1ns/1ps
module tb_ioc_aperture_dec;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              req_vld = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              route_vld, route_coh, route_part, cfg_err;

  always #4 clk = ~clk;

  ioc_aperture_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  typedef struct { logic coh; logic part; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // bench copy of the configuration
  int unsigned m_code = 0, m_base = 0;
  bit m_part = 0, m_en = 0;

  function automatic bit m_err();
    longint unsigned sz, lo;
    sz = (m_code + 12 >= ADDR_W) ? (64'd1 << ADDR_W) : (64'd1 << (m_code + 12));
    lo = longint'(m_base) << 12;
    return (lo % sz) != 0;
  endfunction

  function automatic bit m_hit(input longint unsigned a);
    longint unsigned sz, lo;
    sz = (m_code + 12 >= ADDR_W) ? (64'd1 << ADDR_W) : (64'd1 << (m_code + 12));
    lo = longint'(m_base) << 12;
    return m_en && !m_err() && a >= lo && a < lo + sz;
  endfunction

  task automatic chk(input string r, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input int o, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'(o); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    case (o)
      0: m_code = d[4:0];
      1: m_base = d[19:0];
      2: m_part = d[0];
      default: m_en = d[0];
    endcase
  endtask

  task automatic rd(input int o, input logic [31:0] exp, input string r);
    @(negedge clk);
    reg_rd = 1; reg_addr = 2'(o);
    @(negedge clk);
    reg_rd = 0;
    chk(r, reg_rdata, exp);
  endtask

  task automatic req(input logic [31:0] a, input string r);
    exp_t e;
    @(negedge clk);
    req_vld = 1; req_addr = a;
    e.coh = m_hit(a); e.part = m_hit(a) && m_part; e.tag = r;
    sb.push_back(e);
    @(negedge clk);
    req_vld = 0;
  endtask

  // monitor: pop expected decisions as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (route_vld) begin
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9 unexpected route_vld actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " coh"}, route_coh, e.coh);
          chk({e.tag, " part(R8)"}, route_part, e.part);
        end
      end else begin
        chk("R9 idle coh", route_coh, 0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 route_vld", route_vld, 0);
    chk("R1 cfg_err", cfg_err, 0);
    for (int o = 0; o < 4; o++) rd(o, 0, "R1 reg");

    // R2 readback and reserved bits
    wr(0, 32'hFFFF_FFF1);  rd(0, 32'h11, "R2 size");
    wr(1, 32'hFFF2_0000);  rd(1, 32'h2_0000, "R2 base");
    wr(2, 32'hFFFF_FFFF);  rd(2, 32'h1, "R2 mode");
    rd(3, 32'h0, "R2 en");
    chk("R6 aligned err", cfg_err, m_err());

    // R4 disabled
    req(32'h2000_0000, "R4 disabled");
    req(32'h3000_0000, "R4 disabled mid");

    // R3/R5 512 MB window, partial on (R8)
    wr(3, 32'h1);
    rd(3, 32'h1, "R2 en on");
    req(32'h2000_0000, "R5 first byte");
    req(32'h3FFF_FFFF, "R5 last byte");
    req(32'h4000_0000, "R5 above");
    req(32'h1FFF_FFFF, "R5 below");
    wr(2, 32'h0);
    req(32'h2ABC_0000, "R8 partial off");

    // R5 4 KB window
    wr(0, 0); wr(1, 32'h12345);
    chk("R6 4k aligned", cfg_err, 0);
    req(32'h1234_5000, "R5 page first");
    req(32'h1234_5FFF, "R5 page last");
    req(32'h1234_6000, "R5 page above");
    req(32'h1234_4FFF, "R5 page below");

    // R6 misalignment: size write against unaligned base
    wr(0, 32'h11);
    chk("R6 err set", cfg_err, 1);
    req(32'h1234_5000, "R6 err miss");
    wr(1, 32'h20001);
    chk("R6 err stays", cfg_err, 1);
    wr(2, 32'h1);
    chk("R6 err unaffected by mode", cfg_err, 1);
    req(32'h2000_1000, "R6 err miss2");
    wr(1, 32'h40000);
    chk("R6 err cleared", cfg_err, 0);
    req(32'h4000_0000, "R3 after clear");
    req(32'h5FFF_F000, "R3 after clear last");
    req(32'h6000_0000, "R3 after clear above");

    // R7 clamp
    wr(0, 32'h1F);
    chk("R7 nonzero base err", cfg_err, 1);
    req(32'h4000_0000, "R7 err miss");
    wr(1, 0);
    chk("R7 base0 ok", cfg_err, 0);
    req(32'h0000_0000, "R7 low");
    req(32'hFFFF_FFFF, "R7 high");
    wr(0, 32'h14);
    req(32'h8000_0000, "R7 exact width");
    wr(0, 32'h13);
    req(32'h8000_0000, "R7 half above");
    req(32'h7FFF_FFFF, "R7 half inside");

    // R9 back-to-back requests
    @(negedge clk);
    req_vld = 1; req_addr = 32'h1000;
    begin exp_t e; e.coh = m_hit(32'h1000); e.part = e.coh && m_part; e.tag = "R9 b2b0"; sb.push_back(e); end
    @(negedge clk);
    req_addr = 32'hC000_0000;
    begin exp_t e; e.coh = m_hit(32'hC000_0000); e.part = e.coh && m_part; e.tag = "R9 b2b1"; sb.push_back(e); end
    @(negedge clk);
    req_vld = 0;
    repeat (3) @(negedge clk);
    chk("R9 drained", sb.size(), 0);
    finish_run();
  end
endmodule